// File: doc/BRIEF.md
# Dual-Mode FIFO With Status Flags

This block is a single-clock first-in first-out buffer for an 18-bit data path that can also run as a 9-bit path with twice the number of locations. Three straps are captured while master reset is held. The first picks the read timing: in standard timing every word must be asked for with a read enable, and in fall-through timing the oldest word is placed on the output by itself and stays there until a read enable takes it. The second picks the data width. The third picks which of two default threshold offsets is loaded.

Besides the read-side and write-side flags, whose meaning follows the read timing, the block drives half-full, almost-empty and almost-full flags. All flags are active low and registered. Threshold offsets come from an outside loader through a strobe and two offset buses. A partial reset empties the buffer but keeps the straps and the offsets. A retransmit input rewinds reading to the first word written since the last reset.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low on a clock edge, the block captures `fwft_strap`, `narrow_strap` and `dflt_strap`, empties the buffer and sets `rd_data` to zero.
- R2: After either reset, `half_n` is high, `aempty_n` is low and `afull_n` is high. In standard timing (`fwft_strap` 0) `rdflag_n` is low and `wrflag_n` is high. In fall-through timing (`fwft_strap` 1) `rdflag_n` is high and `wrflag_n` is low.
- R3: While `prst_n` is low (and `mrst_n` high) on a clock edge, the buffer empties, `rd_data` becomes zero and the flags take their R2 values for the captured timing. The captured straps and the current offsets are kept.
- R4: In standard timing, `rd_en` high while words are stored moves the oldest word to `rd_data` at that edge. `rdflag_n` is low exactly when no word is stored.
- R5: In fall-through timing, `rdflag_n` low means `rd_data` holds the oldest word, and that word stays until `rd_en` takes it. Into an empty buffer, a word written at edge k appears at edge k+1. When a word is taken and at least one more is stored, the next word appears at the same edge. When the last word is taken, `rdflag_n` goes high.
- R6: `wr_en` has no effect when the buffer is full. `rd_en` has no effect when the buffer is empty (standard timing) or when `rdflag_n` is high (fall-through timing).
- R7: In standard timing, `wrflag_n` is low exactly when the stored count equals the capacity. In fall-through timing, `wrflag_n` is low exactly when the count is below the capacity.
- R8: `half_n` is low exactly when the stored count is greater than half the capacity.
- R9: `aempty_n` is low exactly when the count is at most the empty offset. `afull_n` is low exactly when the free space is at most the full offset. Offsets written with `ofs_wr` at edge k are used for the flags from edge k+1.
- R10: Master reset loads both offsets with `DEF_OFS_A` when `dflt_strap` is 0 and with `DEF_OFS_B` when it is 1.
- R11: With `narrow_strap` 0 the capacity is `DEPTH` words of 18 bits. With `narrow_strap` 1 it is 2*`DEPTH` words of which only `wr_data[8:0]` is kept, and `rd_data[17:9]` reads zero.
- R12: `rt_n` low on an edge where both `wr_en` and `rd_en` are low rewinds reading to the first word written since reset, without changing `rd_data` in standard timing. In fall-through timing `rdflag_n` goes high at that edge and the first word appears one edge later. When an enable is high, `rt_n` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| fwft_strap | input | 1 | Read timing strap: 0 standard, 1 fall-through |
| narrow_strap | input | 1 | Width strap: 0 for 18 bits, 1 for 9 bits at double depth |
| dflt_strap | input | 1 | Default offset strap: 0 for DEF_OFS_A, 1 for DEF_OFS_B |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Retransmit request, active low |
| ofs_wr | input | 1 | Strobe that loads both offsets |
| ofs_empty | input | log2(DEPTH)+1 | Empty-side offset value |
| ofs_full | input | log2(DEPTH)+1 | Full-side offset value |
| rd_data | output | 18 | Output register |
| rdflag_n | output | 1 | Empty flag (standard) or output-ready (fall-through), active low |
| wrflag_n | output | 1 | Full flag (standard) or input-ready (fall-through), active low |
| half_n | output | 1 | Half-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
Every output is registered and takes its new value at the same edge that changes the pointers, so the result of a stimulus applied before edge k is due right after edge k. The only exceptions are a fall-through head loaded into an empty output register and the head after a fall-through retransmit, which are due one edge later, and offsets, which reach the flags one edge after they are written. The bench drives inputs after the falling edge, advances a queue-based model at the rising edge, and compares every output at the next falling edge, so each of these latencies is checked in the exact cycle.

// File: rtl/dmf_pkg.sv
// Shared types for the dual-mode FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        rd_mode_e mode;
        logic     narrow;
    } dmf_cfg_t;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic half_n;
        logic aempty_n;
        logic afull_n;
    } dmf_flags_t;

    // Flag values that follow any reset, given the read timing in force.
    function automatic dmf_flags_t reset_flags(input logic fwft);
        dmf_flags_t f;
        f.rd_n     = fwft;
        f.wr_n     = ~fwft;
        f.half_n   = 1'b1;
        f.aempty_n = 1'b0;
        f.afull_n  = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/dmf_cfg.sv
// Configuration and offset registers.
// Captures the three straps during master reset and keeps them until the
// next master reset. Holds the two threshold offsets, loaded with a default
// at master reset and overwritten by the loader strobe afterwards.
// Assumes: partial reset does not reach this module.
module dmf_cfg
    import dmf_pkg::*;
#(
    parameter int OW        = 5,
    parameter int DEF_OFS_A = 3,
    parameter int DEF_OFS_B = 12
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          fwft_strap,
    input  logic          narrow_strap,
    input  logic          dflt_strap,
    input  logic          ofs_wr,
    input  logic [OW-1:0] ofs_empty_in,
    input  logic [OW-1:0] ofs_full_in,
    output dmf_cfg_t      cfg_o,
    output logic [OW-1:0] ofs_e_o,
    output logic [OW-1:0] ofs_f_o
);

    localparam logic [OW-1:0] DFLT_A = OW'(DEF_OFS_A);
    localparam logic [OW-1:0] DFLT_B = OW'(DEF_OFS_B);

    // Strap capture during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg_o.mode   <= fwft_strap ? MODE_FWFT : MODE_STD;
            cfg_o.narrow <= narrow_strap;
        end
    end

    // Offset registers: default at master reset, loader value on strobe.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ofs_e_o <= dflt_strap ? DFLT_B : DFLT_A;
            ofs_f_o <= dflt_strap ? DFLT_B : DFLT_A;
        end else if (ofs_wr) begin
            ofs_e_o <= ofs_empty_in;
            ofs_f_o <= ofs_full_in;
        end
    end

endmodule

// File: rtl/dmf_store.sv
// Two-bank word storage with width packing.
// Each bank holds DEPTH half-words. In wide mode one address selects a row
// and both banks form one full word. In narrow mode the low address bit
// picks the bank and the remaining bits pick the row, giving 2*DEPTH
// half-words. The read port is combinational so that the caller can register
// the result in its output register.
// Assumes: DEPTH is a power of two; the caller never writes an unread slot.
module dmf_store #(
    parameter int AW = 4,
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          narrow,
    input  logic          we,
    input  logic [AW:0]   waddr,
    input  logic [2*HW-1:0] wdata,
    input  logic [AW:0]   raddr,
    output logic [2*HW-1:0] rdata
);

    localparam int ROWS = 1 << AW;

    logic [AW-1:0] wrow;
    logic [AW-1:0] rrow;
    logic [HW-1:0] bank_rd [2];

    // Row selection for both ports, depending on width.
    always_comb begin
        wrow = narrow ? waddr[AW:1] : waddr[AW-1:0];
        rrow = narrow ? raddr[AW:1] : raddr[AW-1:0];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [HW-1:0] mem [ROWS];
        logic          bank_we;
        logic [HW-1:0] bank_wd;

        // Bank write enable and write half-word selection.
        always_comb begin
            bank_we = we && (!narrow || (waddr[0] == 1'(b)));
            bank_wd = narrow ? wdata[HW-1:0] : wdata[b*HW +: HW];
        end

        // Storage array write.
        always_ff @(posedge clk) begin
            if (bank_we) begin
                mem[wrow] <= bank_wd;
            end
        end

        assign bank_rd[b] = mem[rrow];
    end

    // Read word assembly: zero-extended half-word or both halves.
    always_comb begin
        if (narrow) begin
            rdata = {{HW{1'b0}}, bank_rd[raddr[0]]};
        end else begin
            rdata = {bank_rd[1], bank_rd[0]};
        end
    end

endmodule

// File: rtl/dmf_flags.sv
// Registered status flags.
// Computes every flag from the occupancy that will hold after the current
// edge, so each flag changes at the same edge as the pointers. Resets force
// the documented start values for the read timing in force.
// Assumes: offsets are below the capacity for almost-full to start high.
module dmf_flags
    import dmf_pkg::*;
#(
    parameter int PW = 6,
    parameter int OW = 5
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_strap,
    input  dmf_cfg_t      cfg,
    input  logic [PW-1:0] cnt_nxt,
    input  logic [PW-1:0] cap,
    input  logic          ov_nxt,
    input  logic [OW-1:0] ofs_e,
    input  logic [OW-1:0] ofs_f,
    output dmf_flags_t    flags
);

    logic [PW-1:0] free_nxt;
    logic [PW-1:0] ofs_e_w;
    logic [PW-1:0] ofs_f_w;
    logic          fwft;
    dmf_flags_t    calc;

    // Next-state flag values from the next occupancy.
    always_comb begin
        fwft          = (cfg.mode == MODE_FWFT);
        free_nxt      = cap - cnt_nxt;
        ofs_e_w       = PW'(ofs_e);
        ofs_f_w       = PW'(ofs_f);
        calc.rd_n     = fwft ? ~ov_nxt : (cnt_nxt != '0);
        calc.wr_n     = fwft ? (cnt_nxt == cap) : (cnt_nxt != cap);
        calc.half_n   = ~(cnt_nxt > (cap >> 1));
        calc.aempty_n = ~(cnt_nxt <= ofs_e_w);
        calc.afull_n  = ~(free_nxt <= ofs_f_w);
    end

    // Flag register with reset start values.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            flags <= reset_flags(fwft_strap);
        end else if (!prst_n) begin
            flags <= reset_flags(fwft);
        end else begin
            flags <= calc;
        end
    end

endmodule

// File: rtl/dual_mode_fifo.sv
// Single-clock FIFO with selectable read timing and width.
// Keeps write and read pointers two bits wider than the row address, so
// their difference is the word count up to 2*DEPTH. Standard timing moves
// a word into the output register on every accepted read. Fall-through
// timing keeps the oldest word in the output register with a valid bit and
// refills it when the word is taken. Retransmit rewinds the read pointer.
// Assumes: straps are stable around master reset; a retransmit follows fewer
// than a capacity of writes since the last reset.
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int HALF_W    = 9,
    parameter int DEF_OFS_A = 3,
    parameter int DEF_OFS_B = 12
) (
    input  logic                     clk,
    input  logic                     mrst_n,
    input  logic                     prst_n,
    input  logic                     fwft_strap,
    input  logic                     narrow_strap,
    input  logic                     dflt_strap,
    input  logic                     wr_en,
    input  logic [2*HALF_W-1:0]      wr_data,
    input  logic                     rd_en,
    input  logic                     rt_n,
    input  logic                     ofs_wr,
    input  logic [$clog2(DEPTH):0]   ofs_empty,
    input  logic [$clog2(DEPTH):0]   ofs_full,
    output logic [2*HALF_W-1:0]      rd_data,
    output logic                     rdflag_n,
    output logic                     wrflag_n,
    output logic                     half_n,
    output logic                     aempty_n,
    output logic                     afull_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 2;
    localparam int OW = AW + 1;
    localparam int DW = 2 * HALF_W;
    localparam logic [PW-1:0] CAP_WIDE   = PW'(DEPTH);
    localparam logic [PW-1:0] CAP_NARROW = PW'(2 * DEPTH);

    dmf_cfg_t      cfg_q;
    logic [OW-1:0] ofs_e_q;
    logic [OW-1:0] ofs_f_q;
    dmf_flags_t    flags_q;

    logic [PW-1:0] wptr_q, rptr_q;
    logic [PW-1:0] wptr_nxt, rptr_nxt;
    logic [PW-1:0] cnt, cnt_nxt, cap;
    logic          ov_q, ov_nxt;
    logic [DW-1:0] dout_q;
    logic [DW-1:0] store_rd;
    logic [PW-1:0] raddr;
    logic          fwft_on;
    logic          wr_ok, rd_ok, take, rt_go, load;

    dmf_cfg #(
        .OW        (OW),
        .DEF_OFS_A (DEF_OFS_A),
        .DEF_OFS_B (DEF_OFS_B)
    ) u_cfg (
        .clk          (clk),
        .mrst_n       (mrst_n),
        .fwft_strap   (fwft_strap),
        .narrow_strap (narrow_strap),
        .dflt_strap   (dflt_strap),
        .ofs_wr       (ofs_wr),
        .ofs_empty_in (ofs_empty),
        .ofs_full_in  (ofs_full),
        .cfg_o        (cfg_q),
        .ofs_e_o      (ofs_e_q),
        .ofs_f_o      (ofs_f_q)
    );

    // Occupancy, capacity and per-edge decisions.
    always_comb begin
        fwft_on = (cfg_q.mode == MODE_FWFT);
        cap     = cfg_q.narrow ? CAP_NARROW : CAP_WIDE;
        cnt     = wptr_q - rptr_q;
        rt_go   = !rt_n && !wr_en && !rd_en;
        wr_ok   = wr_en && (cnt < cap);
        rd_ok   = !fwft_on && rd_en && (cnt != '0);
        take    = fwft_on && rd_en && ov_q;
        if (rt_go) begin
            load = 1'b0;
        end else if (!fwft_on) begin
            load = rd_ok;
        end else if (take) begin
            load = (cnt >= PW'(2));
        end else begin
            load = !ov_q && (cnt != '0);
        end
        raddr = take ? (rptr_q + PW'(1)) : rptr_q;
    end

    // Next pointers, valid bit and occupancy.
    always_comb begin
        wptr_nxt = wptr_q + PW'(wr_ok);
        if (rt_go) begin
            rptr_nxt = '0;
        end else if (rd_ok || take) begin
            rptr_nxt = rptr_q + PW'(1);
        end else begin
            rptr_nxt = rptr_q;
        end
        if (!fwft_on || rt_go) begin
            ov_nxt = 1'b0;
        end else if (take) begin
            ov_nxt = (cnt >= PW'(2));
        end else begin
            ov_nxt = ov_q || (cnt != '0);
        end
        cnt_nxt = wptr_nxt - rptr_nxt;
    end

    dmf_store #(
        .AW (AW),
        .HW (HALF_W)
    ) u_store (
        .clk    (clk),
        .narrow (cfg_q.narrow),
        .we     (wr_ok),
        .waddr  (wptr_q[AW:0]),
        .wdata  (wr_data),
        .raddr  (raddr[AW:0]),
        .rdata  (store_rd)
    );

    // Pointer, valid-bit and output register update.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ov_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            wptr_q <= wptr_nxt;
            rptr_q <= rptr_nxt;
            ov_q   <= ov_nxt;
            if (load) begin
                dout_q <= store_rd;
            end
        end
    end

    dmf_flags #(
        .PW (PW),
        .OW (OW)
    ) u_flags (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .prst_n     (prst_n),
        .fwft_strap (fwft_strap),
        .cfg        (cfg_q),
        .cnt_nxt    (cnt_nxt),
        .cap        (cap),
        .ov_nxt     (ov_nxt),
        .ofs_e      (ofs_e_q),
        .ofs_f      (ofs_f_q),
        .flags      (flags_q)
    );

    assign rd_data  = dout_q;
    assign rdflag_n = flags_q.rd_n;
    assign wrflag_n = flags_q.wr_n;
    assign half_n   = flags_q.half_n;
    assign aempty_n = flags_q.aempty_n;
    assign afull_n  = flags_q.afull_n;

endmodule

// File: rtl/dmf_fifo_chk.sv
// Assertion checker for dual_mode_fifo, attached with bind below.
// Relates port behaviour over consecutive edges and the occupancy against
// the capacity chosen at master reset.
module dmf_fifo_chk #(
    parameter int PW = 6,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt_n,
    input logic [DW-1:0] rd_data,
    input logic          rdflag_n,
    input logic          wrflag_n,
    input logic          half_n,
    input logic          aempty_n,
    input logic          fwft_on,
    input logic [PW-1:0] cnt,
    input logic [PW-1:0] cap
);

    // R1: master reset clears the output register.
    a_r1_master_clears: assert property (@(posedge clk)
        !mrst_n |=> (rd_data == '0));

    // R3: partial reset clears output and re-initialises flags.
    a_r3_partial_clears: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (rd_data == '0) && half_n && !aempty_n);

    // R5: a presented head is held until it is taken.
    a_r5_head_held: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (fwft_on && !rdflag_n && !rd_en && rt_n) |=> ($stable(rd_data) && !rdflag_n));

    // R6: a write into a full buffer changes nothing.
    a_r6_full_write_ignored: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!fwft_on && !wrflag_n && wr_en && !rd_en) |=> !wrflag_n);

    // R6: a read from an empty buffer changes nothing.
    a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!fwft_on && !rdflag_n && rd_en && !wr_en) |=> ($stable(rd_data) && !rdflag_n));

    // R7: occupancy never exceeds the capacity.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        cnt <= cap);

    // R8: a full buffer in standard timing is also more than half full.
    a_r8_full_implies_half: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!fwft_on && !wrflag_n) |-> !half_n);

endmodule

bind dual_mode_fifo dmf_fifo_chk #(
    .PW (PW),
    .DW (DW)
) u_chk (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rt_n     (rt_n),
    .rd_data  (rd_data),
    .rdflag_n (rdflag_n),
    .wrflag_n (wrflag_n),
    .half_n   (half_n),
    .aempty_n (aempty_n),
    .fwft_on  (fwft_on),
    .cnt      (cnt),
    .cap      (cap)
);

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;

    localparam int N  = 16;
    localparam int AW = 4;
    localparam int OW = AW + 1;
    localparam int DA = 3;
    localparam int DB = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          fwft_strap = 1'b0, narrow_strap = 1'b0, dflt_strap = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1, ofs_wr = 1'b0;
    logic [17:0]   wr_data = '0;
    logic [OW-1:0] ofs_empty = '0, ofs_full = '0;
    logic [17:0]   rd_data;
    logic          rdflag_n, wrflag_n, half_n, aempty_n, afull_n;

    dual_mode_fifo #(.DEPTH(N), .HALF_W(9), .DEF_OFS_A(DA), .DEF_OFS_B(DB)) u_dual_mode_fifo (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_strap(fwft_strap),
        .narrow_strap(narrow_strap), .dflt_strap(dflt_strap), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rt_n(rt_n), .ofs_wr(ofs_wr),
        .ofs_empty(ofs_empty), .ofs_full(ofs_full), .rd_data(rd_data),
        .rdflag_n(rdflag_n), .wrflag_n(wrflag_n), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    // Reference model state.
    bit          m_fwft, m_narrow, m_ov;
    int          m_oe, m_of, rd_idx;
    logic [17:0] hist[$];
    logic [17:0] m_dout;
    bit          e_rd, e_wr, e_hf, e_ae, e_af;

    int    checks = 0, errors = 0, cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";
    logic [15:0] lfsr = 16'hACE1;

    task automatic clear_model();
        hist.delete();
        rd_idx = 0; m_ov = 0; m_dout = '0;
        e_rd = m_fwft; e_wr = !m_fwft; e_hf = 1; e_ae = 0; e_af = 1;
    endtask

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_edge();
        int cap, cnt, ncnt;
        if (!mrst_n) begin
            m_fwft = fwft_strap; m_narrow = narrow_strap;
            m_oe = dflt_strap ? DB : DA; m_of = m_oe;
            clear_model();
        end else if (!prst_n) begin
            clear_model();
            if (ofs_wr) begin m_oe = ofs_empty; m_of = ofs_full; end
        end else begin
            cap = m_narrow ? 2 * N : N;
            cnt = hist.size() - rd_idx;
            if (!rt_n && !wr_en && !rd_en) begin
                rd_idx = 0; m_ov = 0;
            end else if (!m_fwft) begin
                if (rd_en && cnt > 0) begin m_dout = hist[rd_idx]; rd_idx++; end
            end else if (rd_en && m_ov) begin
                rd_idx++;
                if (cnt >= 2) m_dout = hist[rd_idx]; else m_ov = 0;
            end else if (!m_ov && cnt > 0) begin
                m_dout = hist[rd_idx]; m_ov = 1;
            end
            if (wr_en && cnt < cap)
                hist.push_back(m_narrow ? {9'b0, wr_data[8:0]} : wr_data);
            ncnt = hist.size() - rd_idx;
            e_rd = m_fwft ? !m_ov : (ncnt != 0);
            e_wr = m_fwft ? (ncnt == cap) : (ncnt != cap);
            e_hf = !(ncnt > cap / 2);
            e_ae = !(ncnt <= m_oe);
            e_af = !((cap - ncnt) <= m_of);
            if (ofs_wr) begin m_oe = ofs_empty; m_of = ofs_full; end
        end
    endtask

    task automatic chk(input string name, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", phase, name, act, exp);
        end
    endtask

    task automatic compare();
        chk("rd_data", rd_data, m_dout);
        chk("rdflag_n", 18'(rdflag_n), 18'(e_rd));
        chk("wrflag_n", 18'(wrflag_n), 18'(e_wr));
        chk("half_n", 18'(half_n), 18'(e_hf));
        chk("aempty_n", 18'(aempty_n), 18'(e_ae));
        chk("afull_n", 18'(afull_n), 18'(e_af));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; rt_n = 1; ofs_wr = 0; mrst_n = 1; prst_n = 1;
    endtask

    task automatic do_wr(input logic [17:0] d);
        idle(); wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic do_rd();
        idle(); rd_en = 1; cyc();
    endtask

    task automatic master(input logic f, input logic nw, input logic df);
        idle(); mrst_n = 0; fwft_strap = f; narrow_strap = nw; dflt_strap = df;
        cyc(); cyc();
        idle(); cyc();
    endtask

    task automatic mixed(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            idle();
            wr_en = lfsr[0] | lfsr[3];
            rd_en = lfsr[1] | (lfsr[5] & lfsr[6]);
            wr_data = {lfsr[15:0], lfsr[2], lfsr[7]};
            cyc();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        phase = "R1 R2 R10";
        master(0, 0, 0);

        phase = "R4 R6 R7 R8 R9 R11";
        for (int i = 0; i < 18; i++) do_wr(18'h2A000 + 18'(i * 37));
        for (int i = 0; i < 18; i++) do_rd();

        phase = "R4";
        for (int i = 0; i < 3; i++) do_wr(18'h15500 + 18'(i));
        for (int i = 0; i < 6; i++) begin
            idle(); wr_en = 1; rd_en = 1; wr_data = 18'h3F000 + 18'(i); cyc();
        end
        for (int i = 0; i < 4; i++) do_rd();

        phase = "R9";
        idle(); ofs_wr = 1; ofs_empty = 5; ofs_full = 2; cyc();
        for (int i = 0; i < 16; i++) do_wr(18'h01111 * 18'(i + 1));
        for (int i = 0; i < 16; i++) do_rd();

        phase = "R3";
        for (int i = 0; i < 6; i++) do_wr(18'h2B0B0 + 18'(i));
        idle(); prst_n = 0; cyc();
        for (int i = 0; i < 16; i++) do_wr(18'h0C0C0 + 18'(i));
        for (int i = 0; i < 3; i++) do_rd();

        phase = "R12";
        idle(); prst_n = 0; cyc();
        for (int i = 0; i < 5; i++) do_wr(18'h20200 + 18'(i));
        for (int i = 0; i < 3; i++) do_rd();
        idle(); rt_n = 0; cyc();
        idle(); rt_n = 0; rd_en = 1; cyc();
        for (int i = 0; i < 6; i++) do_rd();

        phase = "R1 R5 R10 R11";
        master(1, 1, 1);
        do_wr(18'h3FFA5);
        idle(); cyc(); cyc(); cyc();
        do_rd(); do_rd();
        for (int i = 0; i < 34; i++) do_wr(18'h1FE00 + 18'(i * 3));
        for (int i = 0; i < 36; i++) do_rd();

        phase = "R12 R5";
        idle(); prst_n = 0; cyc();
        for (int i = 0; i < 4; i++) do_wr(18'h30300 + 18'(i));
        do_rd(); do_rd();
        idle(); rt_n = 0; cyc();
        idle(); cyc();
        for (int i = 0; i < 5; i++) do_rd();

        phase = "R5 R6 R7 R8 R9";
        mixed(400);

        phase = "R4 R6 R7 R8 R9";
        master(0, 0, 1);
        mixed(400);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule